// File: doc/BRIEF.md
# Ethernet PHY Link-Status Poller over MDIO

This block watches the link state of an external Ethernet PHY without any software help. While the PHY-side role is selected, it waits a fixed number of system clocks and then runs one management read frame: it drives MDC, shifts the frame header out on MDIO, lets go of the line for the turnaround, and clocks in the 16-bit status word that the PHY returns. Once the frame is complete, one bit of that word becomes the link flag. An active-low indicator output follows the flag. The block then waits out the next interval and polls again.

The PHY address has five bits. Its upper three come from a configuration field, which is captured when each frame starts. Its lower two come from a pair of address strap pins. The straps are latched only during reset, and they also fix the 7-bit slave address that the chip presents on its own management bus. When the host-side role is selected, the poller leaves MDC and MDIO idle and reports the link as down.

Top module: `mdio_link_poller`

## Requirements
- R1: While reset is high and afterwards until a frame starts: `mdc`=0, `mdio_oe`=0, `link_up`=0, `link_led_n`=1.
- R2: With `phy_role`=1 and no frame running, a frame starts after POLL_CYCLES idle clocks. Consecutive frame starts are exactly 64*MDC_DIV+POLL_CYCLES clocks apart.
- R3: During a frame, each MDC period is MDC_DIV system clocks: MDC_DIV/2 clocks low followed by MDC_DIV/2 clocks high. MDC starts low and ends low, and `mdio_o` changes only while `mdc` is low.
- R4: The driven bits of a frame, in order, are: 32 ones, start 0,1, read code 1,0, five PHY address bits MSB first, then register address 00001 MSB first.
- R5: PHY address = {cfg_addr_hi[2:0], A1, A0}. `cfg_addr_hi` is taken at frame start. A1/A0 are taken from `strap_a1`/`strap_a0` while reset is high, and strap changes after reset have no effect.
- R6: `mdio_oe` is 1 for bit periods 0..45 of a frame and 0 for the two turnaround periods, the 16 data periods and all idle time.
- R7: Data bits are sampled on MDC rising edges, MSB first. `link_up` takes bit 2 of the 16-bit word at the clock edge on which the frame's last MDC fall occurs, and it changes at no other time while `phy_role`=1.
- R8: `link_led_n` is always the inverse of `link_up`, so it is low when the link is up.
- R9: When `phy_role`=0 at a clock edge, any running frame is abandoned. From the next cycle on, `mdc`=0, `mdio_oe`=0 and `link_up`=0.
- R10: `mgmt_addr` equals 7'h1C with its two low bits replaced by {A1, A0}, which gives 8-bit write addresses 0x38, 0x3A, 0x3C and 0x3E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are latched while it is high |
| phy_role | input | 1 | 1 selects the PHY-side role, in which polling runs |
| cfg_addr_hi | input | 3 | Upper three PHY address bits |
| strap_a1 | input | 1 | Address strap, bit 1 |
| strap_a0 | input | 1 | Address strap, bit 0 |
| mdio_i | input | 1 | MDIO line as received |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| link_up | output | 1 | Link flag from the last complete frame |
| link_led_n | output | 1 | Active-low link indicator |
| mgmt_addr | output | 7 | Own 7-bit management-bus slave address |

## Verification
On every cycle the assertions check that the indicator is the inverse of the flag, that the host role silences MDC and MDIO, that the flag changes only with a frame-ending MDC fall or a role drop, that MDIO data moves only while MDC is low, that a frame opens with a preamble one, and the fixed upper bits of the slave address. The bench's cycle model is the only check of the exact frame content, the poll spacing, the PHY address formed from a field captured at frame start and straps captured at reset, and the choice of bit 2 from the returned word. Scenarios for these use status words that differ only in bit 2, a role drop in the middle of a frame, and a second reset with different straps.

// File: rtl/mdio_poll_pkg.sv
package mdio_poll_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int ADDR_FIRST = 36;
  localparam int REG_FIRST  = 41;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;
  localparam int BIT_W      = 6;

  // Value driven during bit period k of a read frame (bits >= TA_FIRST unused).
  function automatic logic frame_bit(input logic [BIT_W-1:0] k,
                                     input logic [4:0] phy_addr,
                                     input logic [4:0] reg_addr);
    int unsigned ki;
    ki = int'(k);
    if (ki < PRE_BITS)            frame_bit = 1'b1;
    else if (ki == PRE_BITS)      frame_bit = 1'b0;
    else if (ki == PRE_BITS + 1)  frame_bit = 1'b1;
    else if (ki == PRE_BITS + 2)  frame_bit = 1'b1;
    else if (ki == PRE_BITS + 3)  frame_bit = 1'b0;
    else if (ki < REG_FIRST)      frame_bit = phy_addr[3'(4 - (ki - ADDR_FIRST))];
    else if (ki < TA_FIRST)       frame_bit = reg_addr[3'(4 - (ki - REG_FIRST))];
    else                          frame_bit = 1'b0;
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int MDC_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = MDC_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          half_end;

  assign half_end = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (half_end) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign mdc      = mdc_q;
  assign rise_evt = run && half_end && !mdc_q;
  assign fall_evt = run && half_end &&  mdc_q;
endmodule

// File: rtl/mdio_poll_timer.sv
module mdio_poll_timer #(
  parameter int POLL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic start
);
  localparam int TW = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;

  logic [TW-1:0] tmr;

  assign start = en && (tmr == TW'(POLL_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || !en)  tmr <= '0;
    else if (start)  tmr <= '0;
    else             tmr <= tmr + TW'(1);
  end
endmodule

// File: rtl/mdio_strap_latch.sv
module mdio_strap_latch #(
  parameter logic [4:0] SLAVE_BASE = 5'b00111
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strap_a1,
  input  logic       strap_a0,
  output logic [1:0] strap_q,
  output logic [6:0] slave_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strap_q    <= {strap_a1, strap_a0};
      slave_addr <= {SLAVE_BASE, strap_a1, strap_a0};
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_poll_pkg::*;
#(
  parameter logic [4:0] REG_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        abort,
  input  logic        start,
  input  logic        rise_evt,
  input  logic        fall_evt,
  input  logic        mdio_i,
  input  logic [4:0]  phy_addr,
  output logic        active,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_end,
  output logic [15:0] word
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [BIT_W-1:0] bitcnt;
  logic [BIT_W-1:0] nxt;
  logic [4:0]       addr_q;
  logic [15:0]      shreg;

  assign nxt       = bitcnt + BIT_W'(1);
  assign frame_end = active && fall_evt && (bitcnt == LAST_BIT);
  assign word      = shreg;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      active  <= 1'b0;
      bitcnt  <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      addr_q  <= '0;
      shreg   <= '0;
    end else if (start) begin
      active  <= 1'b1;
      bitcnt  <= '0;
      addr_q  <= phy_addr;
      mdio_o  <= frame_bit('0, phy_addr, REG_ADDR);
      mdio_oe <= 1'b1;
    end else if (active) begin
      if (rise_evt && (bitcnt >= BIT_W'(DATA_FIRST)))
        shreg <= {shreg[14:0], mdio_i};
      if (fall_evt) begin
        if (bitcnt == LAST_BIT) begin
          active  <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bitcnt  <= nxt;
          mdio_o  <= frame_bit(nxt, addr_q, REG_ADDR);
          mdio_oe <= (nxt < BIT_W'(TA_FIRST));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_link_poller.sv
module mdio_link_poller #(
  parameter int         MDC_DIV     = 4,
  parameter int         POLL_CYCLES = 1000,
  parameter int         LINK_BIT    = 2,
  parameter logic [4:0] REG_ADDR    = 5'd1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       phy_role,
  input  logic [2:0] cfg_addr_hi,
  input  logic       strap_a1,
  input  logic       strap_a0,
  input  logic       mdio_i,
  output logic       mdc,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       link_up,
  output logic       link_led_n,
  output logic [6:0] mgmt_addr
);
  logic [1:0]  strap_q;
  logic        active;
  logic        start;
  logic        rise_evt;
  logic        fall_evt;
  logic        frame_end;
  logic [15:0] word;

  mdio_strap_latch u_strap (
    .clk(clk), .rst(rst), .strap_a1(strap_a1), .strap_a0(strap_a0),
    .strap_q(strap_q), .slave_addr(mgmt_addr)
  );

  mdio_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .en(phy_role && !active), .start(start)
  );

  mdio_mdc_gen #(.MDC_DIV(MDC_DIV)) u_mdc (
    .clk(clk), .rst(rst), .run(active && phy_role),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_eng #(.REG_ADDR(REG_ADDR)) u_eng (
    .clk(clk), .rst(rst), .abort(!phy_role), .start(start),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .phy_addr({cfg_addr_hi, strap_q}),
    .active(active), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .frame_end(frame_end), .word(word)
  );

  always_ff @(posedge clk) begin
    if (rst || !phy_role) begin
      link_up    <= 1'b0;
      link_led_n <= 1'b1;
    end else if (frame_end) begin
      link_up    <= word[LINK_BIT];
      link_led_n <= !word[LINK_BIT];
    end
  end
endmodule

// File: rtl/mdio_link_poller_chk.sv
module mdio_link_poller_chk (
  input logic       clk,
  input logic       rst,
  input logic       phy_role,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       link_up,
  input logic       link_led_n,
  input logic [6:0] mgmt_addr
);
  // R8
  led_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    link_led_n == !link_up);

  // R9
  host_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !phy_role |=> (!mdc && !mdio_oe && !link_up));

  // R7
  link_update_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_up) |-> ($fell(mdc) || !$past(phy_role)));

  // R3
  data_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> !mdc);

  // R4
  preamble_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> (!mdc && mdio_o));

  // R10
  slave_base_chk: assert property (@(posedge clk) disable iff (rst)
    mgmt_addr[6:2] == 5'b00111);
endmodule

bind mdio_link_poller mdio_link_poller_chk u_chk (
  .clk(clk), .rst(rst), .phy_role(phy_role), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .link_up(link_up), .link_led_n(link_led_n),
  .mgmt_addr(mgmt_addr)
);

// File: tb/sim_mdio_link_poller.sv
`timescale 1ns/1ps
module sim_mdio_link_poller;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int POLL = 20;
  localparam int FLEN = 64 * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phy_role = 1'b1;
  logic [2:0] cfg_addr_hi = 3'b101;
  logic strap_a1 = 1'b1, strap_a0 = 1'b0;
  logic mdio_i = 1'b1;
  logic mdc, mdio_o, mdio_oe, link_up, link_led_n;
  logic [6:0] mgmt_addr;

  int errors = 0;
  int checks = 0;
  logic [15:0] phy_status = 16'h0004;

  always #10 clk = ~clk;

  mdio_link_poller #(.MDC_DIV(DIV), .POLL_CYCLES(POLL)) u0 (
    .clk(clk), .rst(rst), .phy_role(phy_role), .cfg_addr_hi(cfg_addr_hi),
    .strap_a1(strap_a1), .strap_a0(strap_a0), .mdio_i(mdio_i),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .link_up(link_up),
    .link_led_n(link_led_n), .mgmt_addr(mgmt_addr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit   m_active = 0;
  int   t = 0, w = 0;
  bit   m_link = 0;
  bit [1:0] m_strap = 2'b10;
  bit [15:0] m_word = 0;
  bit   fbits[$];

  function automatic void build_frame(input bit [4:0] pa);
    fbits.delete();
    for (int i = 0; i < 32; i++) fbits.push_back(1'b1);
    fbits.push_back(0); fbits.push_back(1);
    fbits.push_back(1); fbits.push_back(0);
    for (int i = 4; i >= 0; i--) fbits.push_back(pa[i]);
    for (int i = 4; i >= 0; i--) fbits.push_back(i == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; w = 0; m_link = 0; m_strap = {strap_a1, strap_a0};
    end else if (!phy_role) begin
      m_active = 0; w = 0; m_link = 0;
    end else if (m_active) begin
      if ((t % DIV) == HALF - 1 && (t / DIV) >= 48) m_word = {m_word[14:0], mdio_i};
      if (t == FLEN - 1) begin
        m_active = 0; w = 0; m_link = m_word[2];
      end else t++;
    end else begin
      if (w == POLL - 1) begin
        m_active = 1; t = 0; w = 0;
        build_frame({cfg_addr_hi, m_strap});
      end else w++;
    end
  end

  // PHY side: returns phy_status in the data periods
  always @(negedge clk) begin
    if (m_active && (t / DIV) >= 48) mdio_i = phy_status[63 - (t / DIV)];
    else mdio_i = 1'b1;
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (!rst) begin
      bit e_mdc, e_oe;
      e_mdc = m_active && ((t % DIV) >= HALF);
      e_oe  = m_active && ((t / DIV) < 46);
      chk(mdc === e_mdc, "R3 mdc", mdc, e_mdc);
      chk(mdio_oe === e_oe, "R6 mdio_oe", mdio_oe, e_oe);
      if (e_oe) chk(mdio_o === fbits[t / DIV], "R4 mdio_o", mdio_o, fbits[t / DIV]);
      chk(link_up === m_link, "R7 link_up", link_up, m_link);
      chk(link_led_n === !m_link, "R8 link_led_n", link_led_n, !m_link);
    end
  end

  task automatic wait_frame_end();
    while (!m_active) @(negedge clk);
    while (m_active) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int c0, c1;
    bit [4:0] addr_seen;
    repeat (4) @(negedge clk);
    // R1 reset state, R10 slave address from straps 1,0
    chk(mdc === 0 && mdio_oe === 0, "R1 idle lines", {mdc, mdio_oe}, 0);
    chk(link_up === 0 && link_led_n === 1, "R1 link reset", {link_up, link_led_n}, 1);
    chk(mgmt_addr === 7'h1E, "R10 slave addr", mgmt_addr, 7'h1E);
    rst = 0;

    // R2 first frame after POLL idle cycles, then period
    c0 = 0;
    while (!mdio_oe) begin @(negedge clk); c0++; end
    chk(c0 == POLL, "R2 first start", c0, POLL);
    // R5 capture address bits at MDC rises
    addr_seen = 0;
    for (int k = 0; k < 46; k++) begin
      @(posedge mdc); #1;
      if (k >= 36 && k < 41) addr_seen = {addr_seen[3:0], mdio_o};
    end
    chk(addr_seen == 5'b10110, "R5 phy address", addr_seen, 5'b10110);
    while (mdio_oe) @(negedge clk);
    wait_frame_end();
    chk(link_up === 1, "R7 link from 0x0004", link_up, 1);
    chk(link_led_n === 0, "R8 led on", link_led_n, 0);

    // R2 start-to-start spacing
    while (mdio_oe) @(negedge clk);
    while (!mdio_oe) @(negedge clk);
    c1 = 0;
    @(negedge clk); c1++;
    while (!(mdio_oe && !m_active === 0 && t == 0)) begin @(negedge clk); c1++; end
    chk(c1 == FLEN + POLL, "R2 poll period", c1, FLEN + POLL);

    // R7 bit 2 clear, others set
    phy_status = 16'hFFFB;
    wait_frame_end();
    wait_frame_end();
    chk(link_up === 0, "R7 link from 0xFFFB", link_up, 0);

    // R5 field change mid-frame and strap change after reset are ignored
    phy_status = 16'h786D;
    while (!m_active) @(negedge clk);
    repeat (20) @(negedge clk);
    cfg_addr_hi = 3'b010; strap_a1 = 0; strap_a0 = 1;
    while (m_active) @(negedge clk);
    chk(link_up === 1, "R7 link from 0x786D", link_up, 1);
    chk(mgmt_addr === 7'h1E, "R5 straps ignored after reset", mgmt_addr, 7'h1E);
    wait_frame_end();

    // R9 role drop mid-frame
    while (!m_active) @(negedge clk);
    repeat (100) @(negedge clk);
    phy_role = 0;
    @(negedge clk);
    chk(mdc === 0 && mdio_oe === 0 && link_up === 0, "R9 abort", {mdc, mdio_oe, link_up}, 0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (mdc !== 0 || mdio_oe !== 0) chk(0, "R9 host idle", {mdc, mdio_oe}, 0);
    end
    chk(link_led_n === 1, "R9 led off", link_led_n, 1);

    // Role back, link returns
    phy_status = 16'h0004;
    phy_role = 1;
    wait_frame_end();
    chk(link_up === 1, "R7 link after role return", link_up, 1);

    // Second reset with straps 0,1
    rst = 1; strap_a1 = 0; strap_a0 = 1; cfg_addr_hi = 3'b000;
    repeat (3) @(negedge clk);
    chk(link_up === 0 && mdio_oe === 0, "R1 second reset", {link_up, mdio_oe}, 0);
    chk(mgmt_addr === 7'h1D, "R10 slave addr 0x1D", mgmt_addr, 7'h1D);
    rst = 0;
    phy_status = 16'hFFFF;
    wait_frame_end();
    chk(link_up === 1, "R7 link from 0xFFFF", link_up, 1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule